// File: doc/BRIEF.md
# Indirect Data-Memory Address Resolver

This block sits between the instruction's file-address field and the data-memory array. Most accesses name a register directly, and the file address passes through as the effective address. Two file addresses are reserved as virtual pointer windows, and neither has storage behind it. When an access names one of these windows, the block uses the contents of that window's own 8-bit pointer register as the effective address. Each pointer can reach any of the 256 locations. Accesses that land at or above a banked boundary take their bank number from a separate bank-select input. Accesses below that boundary always resolve to bank 0.

A pointer can hold the address of one of the windows, so an indirect access can point back at a window. This is a self-reference. A self-referencing read returns all zeros and asks the status logic to set the Zero flag. A self-referencing write is dropped and tells the status logic to leave its flags alone. In both cases the memory array is not enabled.

The resolution is purely combinational, so an indirect access costs no more cycles than a direct one. The block has no data stream of its own. There is no valid/ready handshake, and the caller keeps the request lines steady for the length of the access, so back-pressure does not arise. All pins are plain control and data lines.

Top module: `indirect_addr_unit`

## Requirements
- R1: A file address other than the two window addresses (defaults 0x00 and 0x08) appears unchanged on `eff_addr`.
- R2: A file address equal to window A (default 0x00) gives `eff_addr` equal to `ptr_a`.
- R3: A file address equal to window B (default 0x08) gives `eff_addr` equal to `ptr_b`.
- R4: If `eff_addr` is at or above the banked base (default 0x20), `eff_bank` equals `bank_sel`. Below the base, `eff_bank` is 0.
- R5: A read whose indirect effective address equals either window address drives `rd_data` to 0, drives `zero_set` to 1 and keeps `mem_en` at 0.
- R6: A write whose indirect effective address equals either window address keeps `mem_en` and `mem_we` at 0 and drives `stat_hold` to 1.
- R7: Any other read (`acc_en`=1, `acc_we`=0) drives `mem_en` to 1, copies `mem_rdata` to `rd_data` and keeps `zero_set` at 0.
- R8: Any other write (`acc_en`=1, `acc_we`=1) drives `mem_en` and `mem_we` to 1 and copies `wr_data` to `mem_wdata`. `stat_hold` stays 0.
- R9: With `acc_en`=0, the outputs `mem_en`, `mem_we`, `zero_set`, `stat_hold` and `rd_data` are all 0.
- R10: A change on the inputs is reflected on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_en | input | 1 | The access is active this cycle |
| acc_we | input | 1 | 1 selects a write, 0 selects a read |
| file_addr | input | 8 | File address taken from the instruction |
| wr_data | input | 8 | Write data from the datapath |
| ptr_a | input | 8 | Pointer register for window A |
| ptr_b | input | 8 | Pointer register for window B |
| bank_sel | input | 4 | Bank-select register value |
| mem_rdata | input | 8 | Read data returned by the RAM array |
| eff_bank | output | 4 | Resolved bank number |
| eff_addr | output | 8 | Resolved address within the bank |
| mem_en | output | 1 | RAM array enable |
| mem_we | output | 1 | RAM array write enable |
| mem_wdata | output | 8 | Write data sent to the RAM array |
| rd_data | output | 8 | Read data returned to the datapath |
| zero_set | output | 1 | Forces the Zero status flag to 1 (self-referencing read) |
| stat_hold | output | 1 | Keeps the status flags unchanged (self-referencing write) |

## Verification
The block holds no state, so a wrong window decode or a wrong pointer selection shows on `eff_addr` in the same evaluation as the input that causes it. A wrong self-reference decision shows just as quickly, as a stray `mem_en` or `mem_we`, a nonzero `rd_data`, or a missing `zero_set` or `stat_hold`. The bench therefore changes the inputs and samples the outputs after they settle, before any clock edge. It aims each pointer at each window, including the crossed cases, and it probes addresses on both sides of the banked base.

// File: rtl/iau_pkg.sv
package iau_pkg;
  typedef enum logic [1:0] {
    SRC_DIRECT = 2'd0,
    SRC_PTR_A  = 2'd1,
    SRC_PTR_B  = 2'd2
  } addr_src_e;

  localparam int unsigned NUM_WIN = 2;
endpackage

// File: rtl/iau_route.sv
module iau_route
  import iau_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] WIN_A = 8'h00,
  parameter logic [AW-1:0] WIN_B = 8'h08
) (
  input  logic [AW-1:0] file_addr,
  input  logic [AW-1:0] ptr_a,
  input  logic [AW-1:0] ptr_b,
  output addr_src_e     src,
  output logic [AW-1:0] eff_addr
);
  localparam logic [AW-1:0] WIN_TAB [NUM_WIN] = '{WIN_A, WIN_B};

  logic [NUM_WIN-1:0] hit;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign hit[i] = (file_addr == WIN_TAB[i]);
  end

  always_comb begin
    if (hit[0]) begin
      src      = SRC_PTR_A;
      eff_addr = ptr_a;
    end else if (hit[1]) begin
      src      = SRC_PTR_B;
      eff_addr = ptr_b;
    end else begin
      src      = SRC_DIRECT;
      eff_addr = file_addr;
    end
  end
endmodule

// File: rtl/iau_bank.sv
module iau_bank #(
  parameter int unsigned AW = 8,
  parameter int unsigned BW = 4,
  parameter logic [AW-1:0] BANK_BASE = 8'h20
) (
  input  logic [AW-1:0] eff_addr,
  input  logic [BW-1:0] bank_sel,
  output logic [BW-1:0] eff_bank
);
  logic banked;
  assign banked   = (eff_addr >= BANK_BASE);
  assign eff_bank = banked ? bank_sel : '0;
endmodule

// File: rtl/iau_gate.sv
module iau_gate
  import iau_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] WIN_A = 8'h00,
  parameter logic [AW-1:0] WIN_B = 8'h08
) (
  input  logic          acc_en,
  input  logic          acc_we,
  input  addr_src_e     src,
  input  logic [AW-1:0] eff_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] rd_data,
  output logic          zero_set,
  output logic          stat_hold
);
  localparam logic [AW-1:0] WIN_TAB [NUM_WIN] = '{WIN_A, WIN_B};

  logic [NUM_WIN-1:0] lands_on;
  logic               self_ref;
  logic               live_rd;
  logic               live_wr;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_land
    assign lands_on[i] = (eff_addr == WIN_TAB[i]);
  end

  assign self_ref  = (src != SRC_DIRECT) && (|lands_on);
  assign live_rd   = acc_en && !acc_we;
  assign live_wr   = acc_en && acc_we;

  assign mem_en    = acc_en && !self_ref;
  assign mem_we    = live_wr && !self_ref;
  assign mem_wdata = wr_data;
  assign rd_data   = (live_rd && !self_ref) ? mem_rdata : '0;
  assign zero_set  = live_rd && self_ref;
  assign stat_hold = live_wr && self_ref;
endmodule

// File: rtl/indirect_addr_unit.sv
module indirect_addr_unit
  import iau_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned BW = 4,
  parameter logic [AW-1:0] WIN_A = 8'h00,
  parameter logic [AW-1:0] WIN_B = 8'h08,
  parameter logic [AW-1:0] BANK_BASE = 8'h20
) (
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [AW-1:0] file_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] ptr_a,
  input  logic [AW-1:0] ptr_b,
  input  logic [BW-1:0] bank_sel,
  input  logic [DW-1:0] mem_rdata,
  output logic [BW-1:0] eff_bank,
  output logic [AW-1:0] eff_addr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] rd_data,
  output logic          zero_set,
  output logic          stat_hold
);
  addr_src_e src;

  iau_route #(.AW(AW), .WIN_A(WIN_A), .WIN_B(WIN_B)) u_route (
    .file_addr (file_addr),
    .ptr_a     (ptr_a),
    .ptr_b     (ptr_b),
    .src       (src),
    .eff_addr  (eff_addr)
  );

  iau_bank #(.AW(AW), .BW(BW), .BANK_BASE(BANK_BASE)) u_bank (
    .eff_addr (eff_addr),
    .bank_sel (bank_sel),
    .eff_bank (eff_bank)
  );

  iau_gate #(.AW(AW), .DW(DW), .WIN_A(WIN_A), .WIN_B(WIN_B)) u_gate (
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .src       (src),
    .eff_addr  (eff_addr),
    .wr_data   (wr_data),
    .mem_rdata (mem_rdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .rd_data   (rd_data),
    .zero_set  (zero_set),
    .stat_hold (stat_hold)
  );
endmodule

// File: rtl/iau_chk.sv
module iau_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned BW = 4,
  parameter logic [AW-1:0] WIN_A = 8'h00,
  parameter logic [AW-1:0] WIN_B = 8'h08,
  parameter logic [AW-1:0] BANK_BASE = 8'h20
) (
  input logic          acc_en,
  input logic          acc_we,
  input logic [AW-1:0] file_addr,
  input logic [AW-1:0] ptr_a,
  input logic [AW-1:0] ptr_b,
  input logic [BW-1:0] bank_sel,
  input logic [BW-1:0] eff_bank,
  input logic [AW-1:0] eff_addr,
  input logic          mem_en,
  input logic          mem_we,
  input logic [DW-1:0] rd_data,
  input logic          zero_set,
  input logic          stat_hold
);
  always_comb begin
    if (file_addr == WIN_A)
      a_r2_window_a_uses_ptr: assert (eff_addr == ptr_a);
    if (file_addr == WIN_B && WIN_B != WIN_A)
      a_r3_window_b_uses_ptr: assert (eff_addr == ptr_b);
    if (eff_addr < BANK_BASE)
      a_r4_low_region_bank0: assert (eff_bank == '0);
    if (zero_set)
      a_r5_selfref_read_blank: assert (rd_data == '0 && !mem_en && !acc_we);
    if (stat_hold)
      a_r6_selfref_write_dropped: assert (!mem_we && !mem_en && acc_we);
    if (!acc_en)
      a_r9_idle_quiet: assert (!mem_en && !mem_we && !zero_set && !stat_hold && rd_data == '0);
    a_r5_r6_exclusive: assert (!(zero_set && stat_hold));
  end
endmodule

bind indirect_addr_unit iau_chk #(
  .AW(AW), .DW(DW), .BW(BW), .WIN_A(WIN_A), .WIN_B(WIN_B), .BANK_BASE(BANK_BASE)
) u_chk (
  .acc_en    (acc_en),
  .acc_we    (acc_we),
  .file_addr (file_addr),
  .ptr_a     (ptr_a),
  .ptr_b     (ptr_b),
  .bank_sel  (bank_sel),
  .eff_bank  (eff_bank),
  .eff_addr  (eff_addr),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .rd_data   (rd_data),
  .zero_set  (zero_set),
  .stat_hold (stat_hold)
);

// File: tb/sim_indirect_addr_unit.sv
`timescale 1ns/1ps
module sim_indirect_addr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic       acc_we = 1'b0;
  logic [7:0] file_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ptr_a = '0;
  logic [7:0] ptr_b = '0;
  logic [3:0] bank_sel = '0;
  logic [7:0] mem_rdata = '0;
  logic [3:0] eff_bank;
  logic [7:0] eff_addr;
  logic       mem_en, mem_we, zero_set, stat_hold;
  logic [7:0] mem_wdata, rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  indirect_addr_unit u0 (
    .acc_en(acc_en), .acc_we(acc_we), .file_addr(file_addr), .wr_data(wr_data),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .bank_sel(bank_sel), .mem_rdata(mem_rdata),
    .eff_bank(eff_bank), .eff_addr(eff_addr), .mem_en(mem_en), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .rd_data(rd_data), .zero_set(zero_set), .stat_hold(stat_hold)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit en, input bit we, input logic [7:0] fa);
    @(negedge clk);
    acc_en = en; acc_we = we; file_addr = fa;
    #1;
  endtask

  task automatic t_idle();
    ptr_a = 8'h00; mem_rdata = 8'hA5;
    drive(1'b0, 1'b0, 8'h00);
    check("R9 mem_en", mem_en, 0);
    check("R9 zero_set", zero_set, 0);
    drive(1'b0, 1'b1, 8'h08);
    check("R9 mem_we", mem_we, 0);
    check("R9 stat_hold", stat_hold, 0);
    check("R9 rd_data", rd_data, 0);
  endtask

  task automatic t_direct_read();
    bank_sel = 4'h6; mem_rdata = 8'h3C;
    drive(1'b1, 1'b0, 8'h45);
    check("R1 eff_addr", eff_addr, 8'h45);
    check("R4 banked bank", eff_bank, 4'h6);
    check("R7 mem_en", mem_en, 1);
    check("R7 rd_data", rd_data, 8'h3C);
    check("R7 zero_set", zero_set, 0);
  endtask

  task automatic t_bank_edge();
    bank_sel = 4'h9;
    drive(1'b1, 1'b0, 8'h1F);
    check("R4 below base", eff_bank, 0);
    drive(1'b1, 1'b0, 8'h20);
    check("R4 at base", eff_bank, 4'h9);
  endtask

  task automatic t_ptr_a_read();
    ptr_a = 8'h7F; bank_sel = 4'h2; mem_rdata = 8'h11;
    drive(1'b1, 1'b0, 8'h00);
    check("R2 eff_addr", eff_addr, 8'h7F);
    check("R4 via ptr", eff_bank, 4'h2);
    check("R7 rd via ptr", rd_data, 8'h11);
  endtask

  task automatic t_ptr_b_write();
    ptr_b = 8'h1C; wr_data = 8'hE7; bank_sel = 4'hF;
    drive(1'b1, 1'b1, 8'h08);
    check("R3 eff_addr", eff_addr, 8'h1C);
    check("R4 low via ptr", eff_bank, 0);
    check("R8 mem_we", mem_we, 1);
    check("R8 mem_en", mem_en, 1);
    check("R8 mem_wdata", mem_wdata, 8'hE7);
    check("R8 stat_hold", stat_hold, 0);
  endtask

  task automatic t_selfref_read();
    ptr_a = 8'h08; mem_rdata = 8'hFF;
    drive(1'b1, 1'b0, 8'h00);
    check("R5 rd_data", rd_data, 0);
    check("R5 zero_set", zero_set, 1);
    check("R5 mem_en", mem_en, 0);
    ptr_b = 8'h08;
    drive(1'b1, 1'b0, 8'h08);
    check("R5 own window rd", rd_data, 0);
    check("R5 own window zero", zero_set, 1);
  endtask

  task automatic t_selfref_write();
    ptr_b = 8'h00; wr_data = 8'h5A;
    drive(1'b1, 1'b1, 8'h08);
    check("R6 mem_we", mem_we, 0);
    check("R6 mem_en", mem_en, 0);
    check("R6 stat_hold", stat_hold, 1);
    check("R6 zero_set", zero_set, 0);
  endtask

  task automatic t_comb();
    ptr_a = 8'h30; bank_sel = 4'h4;
    drive(1'b1, 1'b0, 8'h00);
    @(posedge clk); #0.5;
    ptr_a = 8'h91;
    #0.5;
    check("R10 eff_addr no clock", eff_addr, 8'h91);
    ptr_a = 8'h08;
    #0.5;
    check("R10 zero_set no clock", zero_set, 1);
  endtask

  initial begin
    #1;
    check("R9 reset mem_en", mem_en, 0);
    check("R9 reset rd_data", rd_data, 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_direct_read();
    t_bank_edge();
    t_ptr_a_read();
    t_ptr_b_write();
    t_selfref_read();
    t_selfref_write();
    t_comb();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule